// File: doc/BRIEF.md
# Serial Flash Status-Register Responder

This block is the device side of a serial peripheral link. It answers one command of a serial flash: reading the status register. While chip select is low, the host shifts a command byte in on the serial input. The block samples each bit on the rising clock edge, most significant bit first. If the byte is the status-read command, the block drives the 8-bit status word on its serial output. The word repeats for as long as the host keeps chip select low and keeps the clock running. Any other command byte puts the block in a muted state for the rest of the frame.

The status word is rebuilt from live inputs at the start of every repeated byte. These inputs are a busy flag from the array sequencer, the last compare outcome, the protection state and the page-size mode. The host can therefore poll ready/busy inside one long transaction, without toggling chip select. The output pad is modelled as a data bit plus an enable bit. The enable is low whenever the block must leave the line floating.

The command decoder is a three-state machine clocked on the rising clock edge. ST_OPCODE collects the command bits. From it, the transition OPCODE_MATCH leads to ST_STREAM when the eighth bit completes the status-read code, and the transition OPCODE_MISS leads to ST_MUTE for any other code. ST_STREAM and ST_MUTE persist until chip select rises. That event is the transition DESELECT, which returns the machine to ST_OPCODE and clears the bit counter from any state. A transmit shifter on the falling edge loads a fresh status snapshot whenever the bit counter is at zero in ST_STREAM, and otherwise shifts left.

Top module: `fsr_status_responder`

## Requirements
- R1: While cs_n is high, so_oe is 0, and the decoder and bit counter are cleared. A frame aborted part-way through a command does not affect how the next frame is decoded.
- R2: Command bits are sampled on rising sck edges, most significant bit first. During the eight command clocks so_oe stays 0.
- R3: When the command byte equals 0xD7, so_oe rises and status bit 7 appears on so_data at the falling sck edge after the eighth rising edge. Each later bit appears on the following falling edge, in order from bit 7 down to bit 0.
- R4: The status byte is laid out as follows. Bit 7 is the inverse of busy (1 means ready). Bit 6 is cmp_flag. Bits 5 to 2 are the DENSITY_CODE parameter. Bit 1 is protect_on. Bit 0 is page_bin (1 means 256-byte pages, 0 means 264-byte pages).
- R5: After bit 0, the byte starts again from bit 7 without a gap. This repeats for as long as cs_n stays low.
- R6: Each byte is a snapshot taken on the falling edge that launches its bit 7. Input changes in the middle of a byte show up only in the next byte.
- R7: For any command byte other than 0xD7, so_oe stays 0 for the rest of the frame, even if 0xD7 is later shifted in on si.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low; high clears the frame |
| si | input | 1 | Serial data from the host |
| busy | input | 1 | 1 while a self-timed array operation is in progress |
| cmp_flag | input | 1 | Result of the most recent page-to-buffer compare |
| protect_on | input | 1 | Sector protection enabled |
| page_bin | input | 1 | 1 for 256-byte pages, 0 for 264-byte pages |
| so_data | output | 1 | Serial status data to the host |
| so_oe | output | 1 | Output enable for so_data; 0 means the line floats |

## Verification
The bench builds the block with the default 8-bit byte width and the 0xD7 command, and sets DENSITY_CODE to 4'b1011. That code is asymmetric, so a swapped or shifted density field changes the observed byte. The byte width is small, which makes two exhaustive sweeps cheap. One frame walks all 16 combinations of the four live status inputs, one byte each. A second sweep sends all 256 command codes, each in its own frame, and shifts 0xD7 in on si afterwards to confirm that a wrong code cannot be revived within the frame.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_STREAM = 2'd1,
        ST_MUTE   = 2'd2
    } frame_state_e;
endpackage

// File: rtl/fsr_cmd_fsm.sv
`timescale 1ns/1ps
module fsr_cmd_fsm #(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] OPCODE = 8'hD7,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 si,
    output fsr_pkg::frame_state_e state,
    output logic [CNT_W-1:0]     bit_idx
);
    import fsr_pkg::*;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    frame_state_e      state_nx;
    logic [BYTE_W-2:0] op_sh;
    logic [BYTE_W-1:0] op_nx;
    logic              byte_end;

    assign byte_end = (bit_idx == LAST_IDX);
    assign op_nx    = {op_sh, si};

    // State register: cleared asynchronously by deselect
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            state   <= ST_OPCODE;
            bit_idx <= '0;
            op_sh   <= '0;
        end else begin
            state   <= state_nx;
            bit_idx <= byte_end ? '0 : bit_idx + CNT_W'(1);
            op_sh   <= op_nx[BYTE_W-2:0];
        end
    end

    // Transitions: OPCODE_MATCH, OPCODE_MISS; stream and mute persist
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPCODE: begin
                if (byte_end) begin
                    state_nx = (op_nx == OPCODE) ? ST_STREAM : ST_MUTE;
                end
            end
            ST_STREAM: state_nx = ST_STREAM;
            ST_MUTE:   state_nx = ST_MUTE;
            default:   state_nx = ST_MUTE;
        endcase
    end
endmodule

// File: rtl/fsr_status_pack.sv
`timescale 1ns/1ps
module fsr_status_pack #(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-5:0] DENSITY_CODE = 4'b0111
) (
    input  logic              busy,
    input  logic              cmp_flag,
    input  logic              protect_on,
    input  logic              page_bin,
    output logic [BYTE_W-1:0] status
);
    always_comb begin
        status = {~busy, cmp_flag, DENSITY_CODE, protect_on, page_bin};
    end
endmodule

// File: rtl/fsr_tx_shifter.sv
`timescale 1ns/1ps
module fsr_tx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              sck,
    input  logic              cs_n,
    input  logic              stream,
    input  logic              load,
    input  logic [BYTE_W-1:0] snap,
    output logic              so_data,
    output logic              so_oe
);
    logic [BYTE_W-1:0] sh;

    // Launch on the falling edge so the host samples on the rising edge
    always_ff @(negedge sck or posedge cs_n) begin
        if (cs_n) begin
            sh    <= '0;
            so_oe <= 1'b0;
        end else begin
            so_oe <= stream;
            if (stream) begin
                if (load) sh <= snap;
                else      sh <= {sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign so_data = sh[BYTE_W-1];
endmodule

// File: rtl/fsr_status_responder.sv
`timescale 1ns/1ps
module fsr_status_responder #(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] OPCODE = 8'hD7,
    parameter logic [BYTE_W-5:0] DENSITY_CODE = 4'b0111
) (
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic busy,
    input  logic cmp_flag,
    input  logic protect_on,
    input  logic page_bin,
    output logic so_data,
    output logic so_oe
);
    import fsr_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W);

    frame_state_e      state;
    logic [CNT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] status;
    logic              stream;
    logic              load;

    fsr_cmd_fsm #(.BYTE_W(BYTE_W), .OPCODE(OPCODE)) u_fsm (
        .sck    (sck),
        .cs_n   (cs_n),
        .si     (si),
        .state  (state),
        .bit_idx(bit_idx)
    );

    fsr_status_pack #(.BYTE_W(BYTE_W), .DENSITY_CODE(DENSITY_CODE)) u_pack (
        .busy      (busy),
        .cmp_flag  (cmp_flag),
        .protect_on(protect_on),
        .page_bin  (page_bin),
        .status    (status)
    );

    assign stream = (state == ST_STREAM);
    assign load   = (bit_idx == '0);

    fsr_tx_shifter #(.BYTE_W(BYTE_W)) u_tx (
        .sck    (sck),
        .cs_n   (cs_n),
        .stream (stream),
        .load   (load),
        .snap   (status),
        .so_data(so_data),
        .so_oe  (so_oe)
    );
endmodule

// File: rtl/fsr_status_checker.sv
`timescale 1ns/1ps
module fsr_status_checker #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input logic                  sck,
    input logic                  cs_n,
    input fsr_pkg::frame_state_e state,
    input logic [CNT_W-1:0]      bit_idx,
    input logic                  so_oe
);
    import fsr_pkg::*;

    AST_QUIET_DURING_OPCODE: assert property (@(posedge sck) disable iff (cs_n)
        (state == ST_OPCODE) |-> !so_oe);                                              // R2
    AST_LEAVE_OPCODE: assert property (@(posedge sck) disable iff (cs_n)
        (state == ST_OPCODE && bit_idx == CNT_W'(BYTE_W - 1)) |=> (state != ST_OPCODE)); // R3
    AST_STREAM_HOLDS: assert property (@(posedge sck) disable iff (cs_n)
        (state == ST_STREAM) |=> (state == ST_STREAM));                                // R5
    AST_MUTE_HOLDS: assert property (@(posedge sck) disable iff (cs_n)
        (state == ST_MUTE) |=> (state == ST_MUTE && !so_oe));                          // R7
    AST_OE_ONLY_STREAM: assert property (@(posedge sck) disable iff (cs_n)
        so_oe |-> (state == ST_STREAM));                                               // R7
endmodule

bind fsr_status_responder fsr_status_checker #(.BYTE_W(BYTE_W)) u_chk (
    .sck    (sck),
    .cs_n   (cs_n),
    .state  (state),
    .bit_idx(bit_idx),
    .so_oe  (so_oe)
);

// File: tb/tb_fsr_status_responder.sv
`timescale 1ns/1ps
module tb_fsr_status_responder;
    localparam logic [3:0] DENS = 4'b1011;

    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic busy = 1'b0, cmp_flag = 1'b0, protect_on = 1'b0, page_bin = 1'b0;
    logic so_data, so_oe;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #2 sck = ~sck;

    fsr_status_responder #(.DENSITY_CODE(DENS)) dut (
        .sck(sck), .cs_n(cs_n), .si(si), .busy(busy), .cmp_flag(cmp_flag),
        .protect_on(protect_on), .page_bin(page_bin), .so_data(so_data), .so_oe(so_oe)
    );

    function automatic logic [7:0] expect_byte(logic b, logic c, logic p, logic g);
        return {~b, c, DENS, p, g};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_inputs(logic [3:0] v);
        {busy, cmp_flag, protect_on, page_bin} = v;
    endtask

    task automatic clk_bit(input logic din, output logic dout, output logic den);
        @(negedge sck); #1 si = din;
        @(posedge sck); #1 dout = so_data; den = so_oe;
    endtask

    task automatic frame_start();
        @(posedge sck); #1 cs_n = 1'b0;
    endtask

    task automatic frame_end();
        @(negedge sck); #1 cs_n = 1'b1;
        #1;
    endtask

    task automatic shift_byte(input logic [7:0] din, output logic [7:0] dout,
                              output bit all_oe, output bit any_oe);
        logic d, e;
        all_oe = 1'b1; any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(din[i], d, e);
            dout[i] = d;
            all_oe &= e;
            any_oe |= e;
        end
    endtask

    initial begin
        logic [7:0] got;
        bit all_e, any_e;

        // R1: reset state
        #5;
        chk("R1 idle so_oe", {7'b0, so_oe}, 8'h00);

        // Exhaustive status sweep in one frame
        frame_start();
        shift_byte(8'hD7, got, all_e, any_e);
        chk("R2 quiet during opcode", {7'b0, any_e}, 8'h00);
        for (int c = 0; c < 16; c++) begin
            set_inputs(4'(c));
            shift_byte(8'h00, got, all_e, any_e);
            chk((c == 0) ? "R3 first byte after opcode" : "R5 repeat byte", {7'b0, all_e}, 8'h01);
            chk("R4 status layout", got, expect_byte(busy, cmp_flag, protect_on, page_bin));
        end
        frame_end();
        chk("R1 deselect floats", {7'b0, so_oe}, 8'h00);

        // R6: mid-byte change lands in next byte
        frame_start();
        shift_byte(8'hD7, got, all_e, any_e);
        for (int c = 0; c < 16; c++) begin
            logic d, e;
            logic [7:0] old_exp;
            set_inputs(4'(c));
            old_exp = expect_byte(busy, cmp_flag, protect_on, page_bin);
            for (int i = 7; i >= 0; i--) begin
                clk_bit(1'b0, d, e);
                got[i] = d;
                if (i == 4) set_inputs(~4'(c));
            end
            chk("R6 snapshot held over byte", got, old_exp);
            shift_byte(8'h00, got, all_e, any_e);
            chk("R6 new snapshot next byte", got, expect_byte(busy, cmp_flag, protect_on, page_bin));
        end
        frame_end();

        // R1: aborted command does not leak into the next frame
        frame_start();
        for (int i = 0; i < 5; i++) begin
            logic d, e;
            clk_bit(1'b1, d, e);
        end
        frame_end();
        set_inputs(4'b0101);
        frame_start();
        shift_byte(8'hD7, got, all_e, any_e);
        shift_byte(8'h00, got, all_e, any_e);
        chk("R1 fresh decode after abort", got, expect_byte(1'b0, 1'b1, 1'b0, 1'b1));
        frame_end();

        // R7: sweep every command code
        set_inputs(4'b1010);
        for (int op = 0; op < 256; op++) begin
            frame_start();
            shift_byte(8'(op), got, all_e, any_e);
            shift_byte(8'hD7, got, all_e, any_e);
            if (op == 8'hD7) begin
                chk("R3 status command drives", {7'b0, all_e}, 8'h01);
                chk("R4 status in sweep", got, expect_byte(1'b1, 1'b0, 1'b1, 1'b0));
            end else begin
                bit e2;
                e2 = any_e;
                shift_byte(8'hD7, got, all_e, any_e);
                chk("R7 other command stays floating", {7'b0, e2 | any_e}, 8'h00);
            end
            frame_end();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1-path actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule